// File: doc/BRIEF.md
# Converter Serial Control and Readout Port

This block is the slave side of a three-wire-plus-strobes serial link that sits beside a multi-channel data converter. An external master supplies the serial clock and two active-low frame strobes. A write frame shifts a 6-bit control word into the block. The control word picks the input channel, requests a software conversion start, selects standby and chooses the output coding. A read frame shifts a 16-bit word out of the block. That word carries a short header, made of the coding bit and the channel address, followed by the latest 12-bit conversion result.

The serial clock and the strobes are asynchronous to the on-chip clock. They pass through a synchronizer, and the block acts on the falling edges of the serial clock that it detects. The converter core hands over each finished result on a data port with a one-cycle valid strobe. A result that arrives while a read frame is open is held back until the frame closes, so the word being shifted out never changes during a frame. The two strobes may be driven by one wire, so that a write and a read share one frame.

Top module: `adcsp_port`

## Requirements
- R1: After reset the control outputs (chan_sel, soft_start, standby, twos_fmt) are all 0, wr_done is 0 and ser_dout is 0.
- R2: In a write frame, the bits on ser_din at the first six detected falling edges of ser_clk are taken MSB first as {chan_sel[2:0], soft_start, standby, twos_fmt}. The control outputs take the new word once the sixth bit has been taken.
- R3: Falling edges beyond the sixth in the same write frame leave the control outputs unchanged, whatever ser_din carries.
- R4: A write frame that ends (wr_fs_n high) before six falling edges leaves the control outputs unchanged and produces no wr_done pulse.
- R5: Each completed 6-bit write gives exactly one wr_done pulse of one cycle. wr_addr_chg is 1 in that cycle exactly when the new chan_sel differs from the previous value, and it is 0 at all other times.
- R6: A read frame sends 16 bits MSB first: bit 15 = twos_fmt, bits 14:12 = chan_sel, bits 11:0 = coded result. The header uses the control values at the start of the frame. Bit 15 is on ser_dout before the first falling edge, and each falling edge moves to the next bit.
- R7: With twos_fmt = 0 the result is sent unchanged (straight binary). With twos_fmt = 1 its MSB is inverted (twos complement).
- R8: After the sixteenth falling edge of a read frame, and whenever no read frame is open, ser_dout is 0.
- R9: res_data is held as the current result when res_valid is 1. A result that arrives during a read frame does not alter that frame's word, and it becomes current once the frame ends.
- R10: With both strobes low in the same frame, the write and the read both take place. The read header shows the control values from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | On-chip clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock from the master, idle high |
| wr_fs_n | input | 1 | Active-low write frame strobe |
| rd_fs_n | input | 1 | Active-low read frame strobe |
| ser_din | input | 1 | Serial control data in |
| ser_dout | output | 1 | Serial result data out |
| res_data | input | RES_W | Finished conversion result |
| res_valid | input | 1 | One-cycle strobe for res_data |
| chan_sel | output | 3 | Selected channel address |
| soft_start | output | 1 | Software conversion request bit |
| standby | output | 1 | Standby request bit |
| twos_fmt | output | 1 | Output coding: 1 = twos complement |
| wr_done | output | 1 | One-cycle pulse on a completed write |
| wr_addr_chg | output | 1 | With wr_done: the address changed |

## Verification
The bench builds the block with its default values: two synchronizer stages and a 12-bit result. With these values the 16-bit word has exactly the header and data split the requirements describe. The bench drives the serial clock slowly, at six on-chip cycles per half period, so that each serial bit can be sampled well clear of the synchronizer latency. The slow clock also gives room to inject a result midway through a read frame, to run frames with extra and with missing clocks, and to tie both strobes together.

// File: rtl/adcsp_pkg.sv
package adcsp_pkg;

    localparam int CHAN_W = 3;
    localparam int CTRL_W = CHAN_W + 3;

    // Control word layout, MSB first as it arrives on the wire
    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic              soft_start;
        logic              standby;
        logic              twos;
    } ctrl_t;

endpackage

// File: rtl/adcsp_sync.sv
module adcsp_sync #(
    parameter int          STAGES  = 2,
    parameter int          WIDTH   = 4,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    logic [WIDTH-1:0] stg_q [STAGES];
    logic [WIDTH-1:0] stg_d [STAGES];

    always_comb begin
        stg_d[0] = d_in;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stg_q[g] <= RST_VAL;
                end else begin
                    stg_q[g] <= stg_d[g];
                end
            end
        end
    endgenerate

    assign d_out = stg_q[STAGES-1];

endmodule

// File: rtl/adcsp_wr.sv
module adcsp_wr
    import adcsp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  fs_n_s,
    input  logic  sclk_fall,
    input  logic  din_s,
    output ctrl_t ctrl,
    output logic  done,
    output logic  addr_chg
);

    localparam int CNT_W = $clog2(CTRL_W + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CTRL_W - 1);

    typedef struct packed {
        logic              act;
        logic [CNT_W-1:0]  cnt;
        logic [CTRL_W-1:0] sh;
        ctrl_t             ctrl;
        logic              done;
        logic              chg;
        logic              fs_prev;
    } wr_st_t;

    wr_st_t st_q, st_d;
    ctrl_t  nxt_word;

    always_comb begin
        st_d         = st_q;
        st_d.done    = 1'b0;
        st_d.chg     = 1'b0;
        st_d.fs_prev = fs_n_s;
        nxt_word     = ctrl_t'({st_q.sh[CTRL_W-2:0], din_s});

        if (st_q.fs_prev && !fs_n_s) begin
            // frame opens: clear the shifter and bit count
            st_d.act = 1'b1;
            st_d.cnt = '0;
            st_d.sh  = '0;
        end else if (fs_n_s) begin
            // frame closed: an unfinished word is dropped
            st_d.act = 1'b0;
        end else if (st_q.act && sclk_fall && (st_q.cnt <= LAST_IDX)) begin
            st_d.sh  = nxt_word;
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST_IDX) begin
                st_d.ctrl = nxt_word;
                st_d.done = 1'b1;
                st_d.chg  = (nxt_word.chan != st_q.ctrl.chan);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.fs_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl     = st_q.ctrl;
    assign done     = st_q.done;
    assign addr_chg = st_q.chg;

endmodule

// File: rtl/adcsp_rd.sv
module adcsp_rd
    import adcsp_pkg::*;
#(
    parameter int RES_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fs_n_s,
    input  logic              sclk_fall,
    input  logic              hdr_twos,
    input  logic [CHAN_W-1:0] hdr_chan,
    input  logic [RES_W-1:0]  res_data,
    input  logic              res_valid,
    output logic              dout
);

    localparam int WORD_W = 1 + CHAN_W + RES_W;
    localparam int CNT_W  = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] WORD_LEN = CNT_W'(WORD_W);

    typedef struct packed {
        logic              act;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] sh;
        logic [RES_W-1:0]  res;
        logic [RES_W-1:0]  pend;
        logic              pend_v;
        logic              fs_prev;
        logic              dout;
    } rd_st_t;

    rd_st_t           st_q, st_d;
    logic             start;
    logic             busy;
    logic [RES_W-1:0] coded;

    always_comb begin
        st_d         = st_q;
        st_d.fs_prev = fs_n_s;
        start        = st_q.fs_prev && !fs_n_s;
        busy         = !fs_n_s && (st_q.act || start);

        // twos complement form: flip the MSB of the offset-binary value
        coded = st_q.res;
        if (hdr_twos) begin
            coded[RES_W-1] = ~st_q.res[RES_W-1];
        end

        if (start) begin
            st_d.act = 1'b1;
            st_d.cnt = '0;
            st_d.sh  = {hdr_twos, hdr_chan, coded};
        end else if (fs_n_s) begin
            st_d.act = 1'b0;
        end else if (st_q.act && sclk_fall && (st_q.cnt < WORD_LEN)) begin
            st_d.sh  = {st_q.sh[WORD_W-2:0], 1'b0};
            st_d.cnt = st_q.cnt + 1'b1;
        end

        // result holding: defer updates while a frame is open
        if (res_valid) begin
            if (busy) begin
                st_d.pend   = res_data;
                st_d.pend_v = 1'b1;
            end else begin
                st_d.res    = res_data;
                st_d.pend_v = 1'b0;
            end
        end else if (st_q.pend_v && !busy) begin
            st_d.res    = st_q.pend;
            st_d.pend_v = 1'b0;
        end

        st_d.dout = (st_d.act && (st_d.cnt < WORD_LEN)) ? st_d.sh[WORD_W-1] : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.fs_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.dout;

endmodule

// File: rtl/adcsp_port.sv
module adcsp_port
    import adcsp_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int RES_W       = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              wr_fs_n,
    input  logic              rd_fs_n,
    input  logic              ser_din,
    output logic              ser_dout,
    input  logic [RES_W-1:0]  res_data,
    input  logic              res_valid,
    output logic [CHAN_W-1:0] chan_sel,
    output logic              soft_start,
    output logic              standby,
    output logic              twos_fmt,
    output logic              wr_done,
    output logic              wr_addr_chg
);

    // synchronized pin order: {ser_clk, wr_fs_n, rd_fs_n, ser_din}
    localparam int         PIN_N    = 4;
    localparam logic [PIN_N-1:0] PIN_IDLE = 4'b1110;

    typedef struct packed {
        logic sclk_prev;
    } top_st_t;

    logic [PIN_N-1:0] pins_raw, pins_s;
    top_st_t          st_q, st_d;
    logic             sclk_fall;
    ctrl_t            ctrl;

    assign pins_raw = {ser_clk, wr_fs_n, rd_fs_n, ser_din};

    adcsp_sync #(
        .STAGES  (SYNC_STAGES),
        .WIDTH   (PIN_N),
        .RST_VAL (PIN_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pins_raw),
        .d_out (pins_s)
    );

    always_comb begin
        st_d.sclk_prev = pins_s[3];
        sclk_fall      = st_q.sclk_prev && !pins_s[3];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sclk_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    adcsp_wr u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .fs_n_s    (pins_s[2]),
        .sclk_fall (sclk_fall),
        .din_s     (pins_s[0]),
        .ctrl      (ctrl),
        .done      (wr_done),
        .addr_chg  (wr_addr_chg)
    );

    adcsp_rd #(
        .RES_W (RES_W)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .fs_n_s    (pins_s[1]),
        .sclk_fall (sclk_fall),
        .hdr_twos  (ctrl.twos),
        .hdr_chan  (ctrl.chan),
        .res_data  (res_data),
        .res_valid (res_valid),
        .dout      (ser_dout)
    );

    assign chan_sel   = ctrl.chan;
    assign soft_start = ctrl.soft_start;
    assign standby    = ctrl.standby;
    assign twos_fmt   = ctrl.twos;

endmodule

// File: rtl/adcsp_chk.sv
module adcsp_chk #(
    parameter int SYNC_STAGES = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_fs_n,
    input logic       ser_dout,
    input logic       wr_done,
    input logic       wr_addr_chg,
    input logic [2:0] chan_sel,
    input logic       soft_start,
    input logic       standby,
    input logic       twos_fmt
);

    localparam int IDLE_MIN = SYNC_STAGES + 2;

    logic [5:0] ctrl_bus;
    logic [7:0] idle_q;

    assign ctrl_bus = {chan_sel, soft_start, standby, twos_fmt};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_q <= '0;
        end else if (!rd_fs_n) begin
            idle_q <= '0;
        end else if (idle_q != 8'hFF) begin
            idle_q <= idle_q + 8'd1;
        end
    end

    AST_CTRL_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_bus != $past(ctrl_bus)) |-> wr_done); // R4

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> !wr_done); // R5

    AST_CHG_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_addr_chg |-> wr_done); // R5

    AST_CHG_MATCHES_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |-> (wr_addr_chg == (chan_sel != $past(chan_sel)))); // R5

    AST_DOUT_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(idle_q) >= IDLE_MIN) |-> !ser_dout); // R8

endmodule

bind adcsp_port adcsp_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_fs_n     (rd_fs_n),
    .ser_dout    (ser_dout),
    .wr_done     (wr_done),
    .wr_addr_chg (wr_addr_chg),
    .chan_sel    (chan_sel),
    .soft_start  (soft_start),
    .standby     (standby),
    .twos_fmt    (twos_fmt)
);

// File: tb/sim_adcsp_port.sv
`timescale 1ns/1ps
module sim_adcsp_port;

    localparam int HALF = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b1;
    logic        wr_fs_n = 1'b1;
    logic        rd_fs_n = 1'b1;
    logic        ser_din = 1'b0;
    logic        ser_dout;
    logic [11:0] res_data = '0;
    logic        res_valid = 1'b0;
    logic [2:0]  chan_sel;
    logic        soft_start, standby, twos_fmt, wr_done, wr_addr_chg;

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    logic last_chg = 1'b0;
    bit finished = 1'b0;

    bit          inj_en = 1'b0;
    int          inj_at = 0;
    logic [11:0] inj_val = '0;

    always #5 clk = ~clk;

    adcsp_port u0 (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .wr_fs_n(wr_fs_n),
        .rd_fs_n(rd_fs_n), .ser_din(ser_din), .ser_dout(ser_dout),
        .res_data(res_data), .res_valid(res_valid), .chan_sel(chan_sel),
        .soft_start(soft_start), .standby(standby), .twos_fmt(twos_fmt),
        .wr_done(wr_done), .wr_addr_chg(wr_addr_chg)
    );

    always @(posedge clk) begin
        if (rst_n && wr_done) begin
            done_cnt <= done_cnt + 1;
            last_chg <= wr_addr_chg;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] ctrl_now();
        return {chan_sel, soft_start, standby, twos_fmt};
    endfunction

    task automatic push_result(input logic [11:0] v);
        res_data  = v;
        res_valid = 1'b1;
        tick(1);
        res_valid = 1'b0;
        tick(2);
    endtask

    task automatic run_frame(input bit do_wr, input bit do_rd, input logic [5:0] w,
                             input int nclk, output logic [15:0] rd, output bit tail_hi);
        rd = '0;
        tail_hi = 1'b0;
        if (do_wr) wr_fs_n = 1'b0;
        if (do_rd) rd_fs_n = 1'b0;
        tick(HALF);
        for (int i = 0; i < nclk; i++) begin
            if (do_rd) begin
                if (i < 16) rd[15-i] = ser_dout;
                else if (ser_dout) tail_hi = 1'b1;
            end
            ser_din = (i < 6) ? w[5-i] : 1'b1;
            if (inj_en && i == inj_at) begin
                res_data  = inj_val;
                res_valid = 1'b1;
                tick(1);
                res_valid = 1'b0;
            end
            tick(HALF);
            ser_clk = 1'b0;
            tick(HALF);
            ser_clk = 1'b1;
        end
        tick(HALF);
        if (do_rd && nclk >= 16 && ser_dout) tail_hi = 1'b1;
        wr_fs_n = 1'b1;
        rd_fs_n = 1'b1;
        ser_din = 1'b0;
        tick(2 * HALF);
    endtask

    task automatic t_reset();
        chk("R1 ctrl", {26'd0, ctrl_now()}, 32'd0);
        chk("R1 wr_done", {31'd0, wr_done}, 32'd0);
        chk("R1 ser_dout", {31'd0, ser_dout}, 32'd0);
    endtask

    task automatic t_write_basic();
        logic [15:0] rd; bit tl; int d0;
        d0 = done_cnt;
        run_frame(1'b1, 1'b0, 6'b101011, 6, rd, tl);
        chk("R2 ctrl word", {26'd0, ctrl_now()}, {26'd0, 6'b101011});
        chk("R5 done count", done_cnt - d0, 1);
        chk("R5 addr changed", {31'd0, last_chg}, 32'd1);
    endtask

    task automatic t_extra_clocks();
        logic [15:0] rd; bit tl;
        run_frame(1'b1, 1'b0, 6'b011100, 10, rd, tl);
        chk("R3 extra edges ignored", {26'd0, ctrl_now()}, {26'd0, 6'b011100});
    endtask

    task automatic t_short_frame();
        logic [15:0] rd; bit tl; int d0;
        d0 = done_cnt;
        run_frame(1'b1, 1'b0, 6'b110001, 4, rd, tl);
        chk("R4 short frame keeps ctrl", {26'd0, ctrl_now()}, {26'd0, 6'b011100});
        chk("R4 no done pulse", done_cnt - d0, 0);
    endtask

    task automatic t_same_addr();
        logic [15:0] rd; bit tl; int d0;
        d0 = done_cnt;
        run_frame(1'b1, 1'b0, 6'b011000, 6, rd, tl);
        chk("R5 done count same addr", done_cnt - d0, 1);
        chk("R5 no addr change", {31'd0, last_chg}, 32'd0);
    endtask

    task automatic t_read_binary();
        logic [15:0] rd; bit tl;
        push_result(12'hA5C);
        run_frame(1'b0, 1'b1, 6'b0, 18, rd, tl);
        chk("R6 R7 straight binary word", {16'd0, rd}, 32'h3A5C);
        chk("R8 quiet after sixteen", {31'd0, tl}, 32'd0);
        chk("R8 idle dout", {31'd0, ser_dout}, 32'd0);
    endtask

    task automatic t_read_twos();
        logic [15:0] rd; bit tl;
        run_frame(1'b1, 1'b0, 6'b010001, 6, rd, tl);
        run_frame(1'b0, 1'b1, 6'b0, 16, rd, tl);
        chk("R6 R7 twos complement word", {16'd0, rd}, 32'hA25C);
    endtask

    task automatic t_hold_in_frame();
        logic [15:0] rd; bit tl;
        push_result(12'h123);
        inj_en = 1'b1; inj_at = 5; inj_val = 12'h7FF;
        run_frame(1'b0, 1'b1, 6'b0, 16, rd, tl);
        inj_en = 1'b0;
        chk("R9 frame word unchanged", {16'd0, rd}, 32'hA923);
        run_frame(1'b0, 1'b1, 6'b0, 16, rd, tl);
        chk("R9 deferred result applied", {16'd0, rd}, 32'hAFFF);
    endtask

    task automatic t_tied_frame();
        logic [15:0] rd; bit tl;
        run_frame(1'b1, 1'b1, 6'b111000, 16, rd, tl);
        chk("R10 header from old ctrl", {16'd0, rd}, 32'hAFFF);
        chk("R10 write took effect", {26'd0, ctrl_now()}, {26'd0, 6'b111000});
        run_frame(1'b0, 1'b1, 6'b0, 16, rd, tl);
        chk("R10 next read uses new ctrl", {16'd0, rd}, 32'h77FF);
    endtask

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(4);
        t_reset();
        t_write_basic();
        t_extra_clocks();
        t_short_frame();
        t_same_addr();
        t_read_binary();
        t_read_twos();
        t_hold_in_frame();
        t_tied_frame();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #1_900_000;
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule